// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds a small set of wide event counters for a cache controller. Each counter picks one event from a vector of single-cycle event pulses. It adds one in every cycle that the chosen pulse is high. Code 0 is special: it counts every clock, whatever the event vector holds. A single register port carries both kinds of operation. A write stores a counter's event code and its clear-on-read flag. A read returns the counter's value one cycle later.

Each counter has its own clear-on-read flag. When the flag is set, a read returns the value and also empties the counter. Changing a counter's configuration never disturbs the count already gathered. This lets software retarget a counter without losing what it has collected.

Top module: `perf_ctr_bank`

## Requirements
- R1: The bank holds four counters, selected by `reg_idx` values 0 to 3. Each counter is configured, counts and is read independently of the others.
- R2: A write happens in a cycle where `reg_valid` and `reg_write` are both 1. It stores `reg_wdata[5:0]` as the event code and `reg_wdata[6]` as the clear-on-read flag of the counter named by `reg_idx`.
- R3: Event code 0 adds one to the counter in every cycle, whatever the event vector holds.
- R4: Event codes 1 to 53 add one to the counter in each cycle where `evt_pulse[code]` is 1.
- R5: Event codes 54 to 63 never change the counter.
- R6: A read happens in a cycle where `reg_valid` is 1 and `reg_write` is 0. In the next cycle `rd_valid` is 1 and `rd_data` holds the counter's value from the read cycle, taken before that cycle's increment. In every other cycle `rd_valid` is 0.
- R7: With the clear-on-read flag set, a read leaves the counter at 1 if its event fires in the read cycle, and at 0 otherwise.
- R8: With the clear-on-read flag clear, a read does not change the count.
- R9: A configuration write leaves the count unchanged. An event in the write cycle is judged by the old code, and the new code takes effect from the next cycle.
- R10: A counter wraps from its all-ones value to zero without any signal.
- R11: After reset every counter is 0 with event code 0 and clear-on-read off, and `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 54 | One-cycle event pulses, one bit per event code |
| reg_valid | input | 1 | Register operation present this cycle |
| reg_write | input | 1 | 1 = configuration write, 0 = counter read |
| reg_idx | input | 2 | Counter index |
| reg_wdata | input | 7 | Bit 6 = clear-on-read flag, bits 5:0 = event code |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 64 | Counter value returned by a read |

## Verification
The hardest case to reach is a read that clears a counter in the same cycle as that counter's own event. Only that coincidence separates "returns the old value and keeps the new event" from the simpler behaviours. The stimulus holds the selected pulse high across a clear-on-read read, then reads again, and also mixes random pulses with random reads and rewrites over thousands of cycles. Wrap-around cannot be reached with 64 bits in any reasonable run. A second instance with 4-bit counters therefore shares the same stimulus and is compared against the same model, truncated to 4 bits.

// File: rtl/perf_pkg.sv
package perf_pkg;
   localparam int PC_NUM_CTRS   = 4;
   localparam int PC_NUM_EVENTS = 54;
   localparam int PC_CTR_W      = 64;
   localparam int PC_CYCLE_CODE = 0;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
   parameter int NUM_EVENTS = 54,
   parameter int SEL_W      = 6
) (
   input  logic [NUM_EVENTS-1:0] evt_pulse,
   input  logic [SEL_W-1:0]      sel,
   output logic                  hit
);
   localparam int CODES = 1 << SEL_W;
   logic [CODES-1:0] evt_wide;

   generate
      if (CODES == NUM_EVENTS) begin : g_full
         assign evt_wide = evt_pulse;
      end else begin : g_padded
         assign evt_wide = CODES'(evt_pulse);
      end
   endgenerate

   always_comb begin
      if (sel == SEL_W'(perf_pkg::PC_CYCLE_CODE)) hit = 1'b1;
      else                                         hit = evt_wide[sel];
   end
endmodule

// File: rtl/perf_ctr_slot.sv
module perf_ctr_slot #(
   parameter int NUM_EVENTS = 54,
   parameter int SEL_W      = 6,
   parameter int CTR_W      = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_pulse,
   input  logic                  cfg_we,
   input  logic [SEL_W-1:0]      cfg_sel_in,
   input  logic                  cfg_cor_in,
   input  logic                  rd_hit,
   output logic [CTR_W-1:0]      count_q
);
   logic [SEL_W-1:0] sel_q;
   logic             cor_q;
   logic             evt_hit;

   perf_evt_sel #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel (
      .evt_pulse (evt_pulse),
      .sel       (sel_q),
      .hit       (evt_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cor_q <= 1'b0;
      end else if (cfg_we) begin
         sel_q <= cfg_sel_in;
         cor_q <= cfg_cor_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (rd_hit && cor_q)  count_q <= CTR_W'(evt_hit);
      else                       count_q <= count_q + CTR_W'(evt_hit);
   end

   // R7
   clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && cor_q) |=> (count_q == CTR_W'($past(evt_hit))));
   // R8
   keep_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !cor_q) |=> (count_q == $past(count_q) + CTR_W'($past(evt_hit))));
   // R9
   cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (count_q == $past(count_q) + CTR_W'($past(evt_hit))));
   // R3
   cycle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_q == '0) && !(rd_hit && cor_q)) |=> (count_q == $past(count_q) + CTR_W'(1)));
   // R5
   dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(sel_q) >= NUM_EVENTS) && !rd_hit) |=> $stable(count_q));
endmodule

// File: rtl/perf_rd_port.sv
module perf_rd_port #(
   parameter int NUM_CTRS = 4,
   parameter int CTR_W    = 64,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTR_W-1:0] counts [NUM_CTRS],
   input  logic             rd_req,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [CTR_W-1:0] rd_data
);
   logic             idx_ok;
   logic [CTR_W-1:0] pick;

   assign idx_ok = {1'b0, rd_idx} < (IDX_W+1)'(NUM_CTRS);

   always_comb begin
      pick = '0;
      for (int k = 0; k < NUM_CTRS; k++)
         if (rd_idx == IDX_W'(k)) pick = counts[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= idx_ok ? pick : '0;
      end
   end

   // R6
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R6
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rd_valid && $stable(rd_data)));
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
   import perf_pkg::*;
#(
   parameter int NUM_CTRS   = PC_NUM_CTRS,
   parameter int NUM_EVENTS = PC_NUM_EVENTS,
   parameter int CTR_W      = PC_CTR_W,
   localparam int IDX_W     = $clog2(NUM_CTRS),
   localparam int SEL_W     = $clog2(NUM_EVENTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_pulse,
   input  logic                  reg_valid,
   input  logic                  reg_write,
   input  logic [IDX_W-1:0]      reg_idx,
   input  logic [SEL_W:0]        reg_wdata,
   output logic                  rd_valid,
   output logic [CTR_W-1:0]      rd_data
);
   generate
      if (NUM_CTRS < 2) begin : g_bad_ctrs
         $error("perf_ctr_bank: NUM_CTRS must be at least 2");
      end
      if (NUM_EVENTS < 2) begin : g_bad_evts
         $error("perf_ctr_bank: NUM_EVENTS must be at least 2");
      end
      if (CTR_W < 2) begin : g_bad_width
         $error("perf_ctr_bank: CTR_W must be at least 2");
      end
   endgenerate

   logic             rd_req;
   logic [CTR_W-1:0] counts [NUM_CTRS];
   logic [NUM_CTRS-1:0] wr_sel, rd_sel;

   assign rd_req = reg_valid && !reg_write;

   generate
      for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
         assign wr_sel[i] = reg_valid &&  reg_write && (reg_idx == IDX_W'(i));
         assign rd_sel[i] = rd_req && (reg_idx == IDX_W'(i));

         perf_ctr_slot #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W), .CTR_W(CTR_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_pulse  (evt_pulse),
            .cfg_we     (wr_sel[i]),
            .cfg_sel_in (reg_wdata[SEL_W-1:0]),
            .cfg_cor_in (reg_wdata[SEL_W]),
            .rd_hit     (rd_sel[i]),
            .count_q    (counts[i])
         );
      end
   endgenerate

   perf_rd_port #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .counts   (counts),
      .rd_req   (rd_req),
      .rd_idx   (reg_idx),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // R1
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_sel, rd_sel}));
endmodule

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [53:0] evt_pulse = '0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [6:0]  reg_wdata = '0;
   logic        rd_valid, rd_valid_n;
   logic [63:0] rd_data;
   logic [3:0]  rd_data_n;

   always #5 clk = ~clk;

   perf_ctr_bank u0 (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_valid(reg_valid),
      .reg_write(reg_write), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data));

   // narrow copy used to reach wrap-around (R10)
   perf_ctr_bank #(.CTR_W(4)) u1 (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_valid(reg_valid),
      .reg_write(reg_write), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .rd_valid(rd_valid_n), .rd_data(rd_data_n));

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R11";
   bit    done    = 1'b0;

   // behavioural reference model
   longint unsigned m_cnt [4];
   int              m_sel [4];
   bit              m_cor [4];
   bit              exp_valid;
   longint unsigned exp_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 0; m_cor[i] = 0; end
         exp_valid = 0; exp_data = 0;
      end else begin
         exp_valid = reg_valid && !reg_write;
         if (exp_valid) exp_data = m_cnt[reg_idx];
         for (int i = 0; i < 4; i++) begin
            bit h;
            h = (m_sel[i] == 0) ? 1'b1 : (m_sel[i] < 54) ? evt_pulse[m_sel[i]] : 1'b0;
            if (exp_valid && reg_idx == 2'(i) && m_cor[i]) m_cnt[i] = longint'(h);
            else m_cnt[i] = m_cnt[i] + longint'(h);
         end
         if (reg_valid && reg_write) begin
            m_sel[reg_idx] = int'(reg_wdata[5:0]);
            m_cor[reg_idx] = reg_wdata[6];
         end
      end
   end

   task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_req, " R6 valid"}, longint'(rd_valid), longint'(exp_valid));
         check({cur_req, " R10 valid narrow"}, longint'(rd_valid_n), longint'(exp_valid));
         if (exp_valid) begin
            check({cur_req, " R6 data"}, rd_data, exp_data);
            check({cur_req, " R10 data narrow"}, longint'(rd_data_n), exp_data & 64'hF);
         end
      end
   end

   task automatic step(input bit v, input bit w, input int idx, input int wd, input logic [53:0] ev);
      @(negedge clk);
      reg_valid = v; reg_write = w; reg_idx = 2'(idx); reg_wdata = 7'(wd); evt_pulse = ev;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0);
   endtask

   function automatic logic [53:0] rnd_evt();
      return {$urandom, $urandom};
   endfunction

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 rd_valid at reset", longint'(rd_valid), 0);
      check("R11 rd_data at reset", rd_data, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3 R1: all counters on code 0 count cycles
      cur_req = "R3 R1";
      idle(10);
      for (int i = 0; i < 4; i++) step(1, 0, i, 0, rnd_evt());
      idle(2);

      // R2 R4 R5 R7 R8: distinct codes, random pulses
      cur_req = "R2 R4 R5 R7 R8";
      step(1, 1, 0, 0, '0);
      step(1, 1, 1, 5, '0);
      step(1, 1, 2, 64 + 53, '0);
      step(1, 1, 3, 60, '0);
      for (int k = 0; k < 600; k++) begin
         if (k % 7 == 3) step(1, 0, k % 4, 0, rnd_evt());
         else            step(0, 0, 0, 0, rnd_evt());
      end

      // R7: clear-on-read with the event firing in the same cycle
      cur_req = "R7";
      step(1, 0, 2, 0, 54'(1) << 53);
      step(1, 0, 2, 0, '0);
      step(1, 0, 2, 0, '0);
      idle(2);

      // R9: retarget a counter while events flow
      cur_req = "R9";
      for (int k = 0; k < 20; k++) step(0, 0, 0, 0, '1);
      step(1, 1, 1, 7, '1);
      step(1, 0, 1, 0, '1);
      step(1, 1, 1, 64 + 7, 54'(1) << 7);
      step(1, 0, 1, 0, 54'(1) << 7);
      step(1, 0, 1, 0, '0);
      idle(2);

      // R10: run cycle counter long enough to wrap the narrow copy
      cur_req = "R10";
      step(1, 1, 0, 0, '0);
      idle(37);
      step(1, 0, 0, 0, '0);
      idle(2);

      // R1 R2 R4 R6 R7 R8 R9: random mixed operations
      cur_req = "R1 R2 R4 R6 R7 R8 R9";
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r < 3)       step(1, 0, int'($urandom_range(0, 3)), 0, rnd_evt());
         else if (r == 3) step(1, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 127)), rnd_evt());
         else             step(0, 0, 0, 0, rnd_evt());
      end
      for (int i = 0; i < 4; i++) step(1, 0, i, 0, '0);
      idle(3);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(10 * 200000);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule